// File: doc/BRIEF.md
# Flash Embedded-Operation Status Poller

This block watches a parallel NOR flash after a program or erase has already been launched elsewhere. It repeatedly reads the status word at one flash address through a simple read-request master port. It decides from two status bits whether the embedded operation has finished, has failed, or is still running. The first bit toggles on every read while the device is busy. The second bit is a time-limit flag that the device raises when its own internal operation overruns.

A cycle counter, cleared when a poll is started, bounds the whole procedure. A limit of zero ends the poll at once, and the all-ones limit turns the bound off. Before the first status read the poller can optionally wait for the device's ready indication. When it finishes, it reports one of three results together with a one-cycle done pulse.

Top module: `flash_status_poller`

## Requirements
- R1: A poll step reads the same address twice in a row. If bit 6 of the two status words is equal, the poll ends with result code 2'b01 (success).
- R2: If bit 6 differs and bit 5 of the first word of the pair is clear, the operation counts as running and another read pair follows.
- R3: If bit 6 differs and bit 5 of the first word is set, exactly one confirming read pair follows instead of a failure. If bit 6 is equal on that confirming pair, the result is success (2'b01).
- R4: If the confirming pair toggles again and bit 5 of its first word is set, the result is 2'b10 (error).
- R5: If the confirming pair toggles with bit 5 of its first word clear, ordinary polling resumes. A later pair with bit 5 set gets a confirming pair of its own.
- R6: A start with limit 0 gives result 2'b11 (timeout) with done high in the cycle after the start edge. busy stays low and no bus read is issued.
- R7: The cycle counter clears at start and counts every busy cycle. A timeout (2'b11) is declared when the count exceeds the limit, either during the ready wait or after a toggling pair whose first word has bit 5 clear.
- R8: The all-ones limit never produces a timeout, even after the counter saturates.
- R9: With wait_ready set at start, no bus read is issued until dev_ready is high.
- R10: A start while busy is ignored: the address, the limit and the running poll are unchanged, and only one done pulse follows.
- R11: done is a single-cycle pulse with busy low. result is valid with the pulse and held until the next pulse.
- R12: bus_rd is high only while busy. Once raised, bus_rd and bus_addr stay unchanged until bus_ack.
- R13: After reset, busy, done and bus_rd are low and result is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (sampled while idle) |
| poll_addr | input | ADDR_W | Flash address whose status is read |
| tmo_limit | input | CNT_W | Cycle limit; 0 = immediate timeout, all-ones = no timeout |
| wait_ready | input | 1 | Wait for dev_ready before the first read |
| dev_ready | input | 1 | Device ready indication (1 = ready) |
| bus_rd | output | 1 | Read request, held until acknowledged |
| bus_addr | output | ADDR_W | Read address |
| bus_ack | input | 1 | Read acknowledge, bus_rdata valid |
| bus_rdata | input | DATA_W | Read data |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 01 success, 10 error, 11 timeout, 00 after reset |

## Verification
The main function is driven with several kinds of status-word sequence. A pair that is stable at once separates a correct pair compare from a single-read check. Long toggling runs show that a running operation never ends early. A fail-flagged pair followed by a stable pair tells the confirm path apart from an immediate failure, and two flagged toggling pairs must end in error. A flagged pair, then a plain toggling pair, then a flagged pair again shows that the confirm state is re-armed. Limits of zero, a small value, one below all-ones and all-ones separate the immediate, ordinary, boundary and disabled timeout behaviours. A withheld ready signal, a start during a poll, and a slow bus check the ordering of requests and the holding of addresses.

// File: rtl/flash_poll_pkg.sv
// Shared types for the flash status poller.
// Assumes: result encoding is fixed at two bits and is visible at the top ports.
package flash_poll_pkg;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_PASS    = 2'b01,
        RES_FAIL    = 2'b10,
        RES_TIMEOUT = 2'b11
    } poll_res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDY_WAIT,
        ST_RD_FIRST,
        ST_RD_SECOND
    } poll_state_e;

    typedef enum logic [1:0] {
        V_PASS,
        V_CONFIRM,
        V_FAIL,
        V_AGAIN
    } pair_verdict_e;

endpackage

// File: rtl/poll_cycle_timer.sv
// Elapsed-cycle counter for one poll.
// Clears on the start request, counts each busy cycle and saturates at
// all-ones. Flags expiry when the count exceeds the limit; the all-ones
// limit disables expiry.
// Assumes: limit is stable while run is high.
module poll_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Purpose: clear on start, otherwise count busy cycles up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (run && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Purpose: expiry compare, suppressed by the all-ones limit.
    always_comb begin
        expired = (limit != CNT_MAX) && (count_q > limit);
    end

endmodule

// File: rtl/toggle_pair_judge.sv
// Classifies one pair of status reads.
// Equal toggle bits mean the operation has finished. A toggle with the fail
// flag set in the first word asks for one confirming pair; if that pair also
// toggles with the flag set, the operation has failed. Any other toggle means
// it is still running.
// Assumes: the caller stores only the two relevant bits of the first word.
module toggle_pair_judge (
    input  logic                          first_tog,
    input  logic                          first_fail,
    input  logic                          second_tog,
    input  logic                          confirming,
    output flash_poll_pkg::pair_verdict_e verdict
);
    import flash_poll_pkg::*;

    // Purpose: decide the next action from one completed read pair.
    always_comb begin
        if (first_tog == second_tog) begin
            verdict = V_PASS;
        end else if (first_fail) begin
            verdict = confirming ? V_FAIL : V_CONFIRM;
        end else begin
            verdict = V_AGAIN;
        end
    end

endmodule

// File: rtl/flash_status_poller.sv
// Flash embedded-operation status poller (top).
// Reads pairs of status words at a latched address until the toggle bit is
// stable (success), a fail-flagged toggle repeats on a confirming pair
// (error), or the cycle limit runs out (timeout). An optional ready wait
// comes before the first read.
// Assumes: the bus acknowledges each held request eventually; the ready wait
// is bounded by the limit, the reads themselves are not aborted.
module flash_status_poller #(
    parameter int ADDR_W       = 24,
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 16,
    parameter int TOGGLE_BIT   = 6,
    parameter int FAIL_BIT     = 5,
    parameter bit HAS_RDY_WAIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [CNT_W-1:0]  tmo_limit,
    input  logic              wait_ready,
    input  logic              dev_ready,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    import flash_poll_pkg::*;

    poll_state_e       state_q;
    poll_res_e         result_q;
    pair_verdict_e     verdict;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  limit_q;
    logic              first_tog_q;
    logic              first_fail_q;
    logic              confirm_q;
    logic              expired;
    logic              launch;
    logic              rdy_gate;
    logic              rdy_seen;
    logic              unused_rdata_bits;

    assign unused_rdata_bits = ^bus_rdata;

    // Optional ready wait: without it, the inputs are ignored.
    generate
        if (HAS_RDY_WAIT) begin : g_rdy
            assign rdy_gate = wait_ready;
            assign rdy_seen = dev_ready;
        end else begin : g_no_rdy
            logic unused_rdy_pins;
            assign unused_rdy_pins = wait_ready ^ dev_ready;
            assign rdy_gate        = 1'b0;
            assign rdy_seen        = 1'b1;
        end
    endgenerate

    assign launch = (state_q == ST_IDLE) && start;

    poll_cycle_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .run    (state_q != ST_IDLE),
        .limit  (limit_q),
        .expired(expired)
    );

    toggle_pair_judge u_judge (
        .first_tog (first_tog_q),
        .first_fail(first_fail_q),
        .second_tog(bus_rdata[TOGGLE_BIT]),
        .confirming(confirm_q),
        .verdict   (verdict)
    );

    // Purpose: poll sequencing, result capture and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            result_q     <= RES_NONE;
            done_q       <= 1'b0;
            addr_q       <= '0;
            limit_q      <= '0;
            first_tog_q  <= 1'b0;
            first_fail_q <= 1'b0;
            confirm_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q    <= poll_addr;
                        limit_q   <= tmo_limit;
                        confirm_q <= 1'b0;
                        if (tmo_limit == '0) begin
                            done_q   <= 1'b1;
                            result_q <= RES_TIMEOUT;
                        end else if (rdy_gate) begin
                            state_q <= ST_RDY_WAIT;
                        end else begin
                            state_q <= ST_RD_FIRST;
                        end
                    end
                end
                ST_RDY_WAIT: begin
                    if (expired) begin
                        done_q   <= 1'b1;
                        result_q <= RES_TIMEOUT;
                        state_q  <= ST_IDLE;
                    end else if (rdy_seen) begin
                        state_q <= ST_RD_FIRST;
                    end
                end
                ST_RD_FIRST: begin
                    if (bus_ack) begin
                        first_tog_q  <= bus_rdata[TOGGLE_BIT];
                        first_fail_q <= bus_rdata[FAIL_BIT];
                        state_q      <= ST_RD_SECOND;
                    end
                end
                ST_RD_SECOND: begin
                    if (bus_ack) begin
                        unique case (verdict)
                            V_PASS: begin
                                done_q   <= 1'b1;
                                result_q <= RES_PASS;
                                state_q  <= ST_IDLE;
                            end
                            V_FAIL: begin
                                done_q   <= 1'b1;
                                result_q <= RES_FAIL;
                                state_q  <= ST_IDLE;
                            end
                            V_CONFIRM: begin
                                confirm_q <= 1'b1;
                                state_q   <= ST_RD_FIRST;
                            end
                            default: begin
                                if (expired) begin
                                    done_q   <= 1'b1;
                                    result_q <= RES_TIMEOUT;
                                    state_q  <= ST_IDLE;
                                end else begin
                                    confirm_q <= 1'b0;
                                    state_q   <= ST_RD_FIRST;
                                end
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the ports from registered state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        bus_rd   = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
        bus_addr = addr_q;
        done     = done_q;
        result   = result_q;
    end

endmodule

// File: rtl/flash_status_poller_chk.sv
// Port-level protocol checker for flash_status_poller, bound to every instance.
// Assumes: the reset is held for at least one clock edge at time zero.
module flash_status_poller_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  tmo_limit,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result
);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_rd_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> busy);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

    p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (tmo_limit == '0)) |=> (done && !busy && (result == 2'b11)));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(bus_addr));

endmodule

bind flash_status_poller flash_status_poller_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tmo_limit(tmo_limit),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sim_flash_status_poller.sv
module sim_flash_status_poller;
    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int CW   = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [CW-1:0] tmo_limit = '0;
    logic          wait_ready = 1'b0;
    logic          dev_ready = 1'b1;
    logic          bus_rd;
    logic [AW-1:0] bus_addr;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          busy;
    logic          done;
    logic [1:0]    result;

    int tests = 0;
    int fails = 0;

    // flash model state
    logic [DW-1:0] fq[$];
    logic [DW-1:0] last_w = '0;
    logic [DW-1:0] tog_w = '0;
    bit            toggle_forever = 0;
    int            lat = 0;
    int            lat_cnt = 0;
    int            n_reads = 0;

    // reference model state
    bit            m_busy = 0;
    bit            m_done = 0;
    logic [1:0]    m_res = 2'b00;
    int            m_phase = 0;
    int            m_t = 0;
    int            m_lim = 0;
    bit            m_f6 = 0;
    bit            m_f5 = 0;
    bit            m_conf = 0;
    logic [AW-1:0] m_addr = '0;

    always #5 clk = ~clk;

    flash_status_poller #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
        .TOGGLE_BIT(6), .FAIL_BIT(5), .HAS_RDY_WAIT(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
        .tmo_limit(tmo_limit), .wait_ready(wait_ready), .dev_ready(dev_ready),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] next_word();
        if (toggle_forever) begin
            tog_w = tog_w ^ 16'h0040;
            return tog_w;
        end
        if (fq.size() > 0) last_w = fq.pop_front();
        return last_w;
    endfunction

    task automatic m_finish(input logic [1:0] code);
        m_done = 1;
        m_res  = code;
        m_busy = 0;
    endtask

    // Behavioural reference: evaluated on each rising edge from the inputs.
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_busy = 0; m_done = 0; m_res = 2'b00; m_t = 0;
            end else begin
                m_done = 0;
                if (!m_busy) begin
                    if (start) begin
                        m_addr = poll_addr;
                        if (tmo_limit == 0) m_finish(2'b11);
                        else begin
                            m_busy = 1; m_t = 0; m_lim = int'(tmo_limit); m_conf = 0;
                            m_phase = wait_ready ? 0 : 1;
                        end
                    end
                end else begin
                    bit exp_now;
                    exp_now = (m_lim != CMAX) && (m_t > m_lim);
                    if (m_t < CMAX) m_t++;
                    if (m_phase == 0) begin
                        if (exp_now) m_finish(2'b11);
                        else if (dev_ready) m_phase = 1;
                    end else if (m_phase == 1) begin
                        if (bus_ack) begin
                            m_f6 = bus_rdata[6]; m_f5 = bus_rdata[5]; m_phase = 2;
                        end
                    end else if (bus_ack) begin
                        if (m_f6 == bus_rdata[6]) m_finish(2'b01);
                        else if (m_f5 && !m_conf) begin m_conf = 1; m_phase = 1; end
                        else if (m_f5) m_finish(2'b10);
                        else if (exp_now) m_finish(2'b11);
                        else begin m_conf = 0; m_phase = 1; end
                    end
                end
            end
        end
    end

    // Per-cycle comparison at the falling edge, then the flash responder.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(busy == m_busy, "R10/R13 busy", busy, m_busy);
                chk(done == m_done, "R11 done", done, m_done);
                if (m_done) chk(result == m_res, "R1-R8 result", result, m_res);
                chk(bus_rd == (m_busy && m_phase != 0), "R9/R12 bus_rd", bus_rd, m_busy && m_phase != 0);
                if (bus_rd) chk(bus_addr == m_addr, "R12 bus_addr", bus_addr, m_addr);
            end
            if (!rst_n) begin
                bus_ack = 0; lat_cnt = 0;
            end else if (bus_ack) begin
                bus_ack = 0; lat_cnt = 0;
            end else if (bus_rd) begin
                if (lat_cnt >= lat) begin
                    bus_ack = 1; bus_rdata = next_word(); n_reads++;
                end else lat_cnt++;
            end else lat_cnt = 0;
        end
    end

    task automatic launch(input logic [AW-1:0] a, input int lim, input bit wr);
        @(negedge clk);
        poll_addr = a; tmo_limit = CW'(lim); wait_ready = wr; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(output logic [1:0] r);
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R11 done seen", done, 1);
        r = result;
    endtask

    task automatic push_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
        fq.push_back(a);
        fq.push_back(b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [1:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk(busy == 0, "R13 busy", busy, 0);
        chk(done == 0, "R13 done", done, 0);
        chk(bus_rd == 0, "R13 bus_rd", bus_rd, 0);
        chk(result == 2'b00, "R13 result", result, 0);

        // R1 stable at once
        fq.delete(); push_pair(16'h0044, 16'h0044);
        launch(20'h12340, 10, 0); wait_done(r);
        chk(r == 2'b01, "R1 stable pair", r, 1);

        // R2 toggling pairs then stable
        fq.delete(); push_pair(16'h0040, 16'h0000); push_pair(16'h0000, 16'h0040); push_pair(16'h0040, 16'h0040);
        launch(20'h00100, 50, 0); wait_done(r);
        chk(r == 2'b01, "R2 keep polling", r, 1);

        // R3 flagged toggle, stable confirm pair
        fq.delete(); push_pair(16'h0060, 16'h0020); push_pair(16'h0024, 16'h0024);
        launch(20'h00200, 50, 0); wait_done(r);
        chk(r == 2'b01, "R3 confirm pass", r, 1);

        // R4 flagged toggle twice
        fq.delete(); push_pair(16'h0060, 16'h0020); push_pair(16'h0020, 16'h0060);
        launch(20'h00300, 50, 0); wait_done(r);
        chk(r == 2'b10, "R4 error", r, 2);

        // R5 confirm pair clean toggle, re-armed confirm later
        fq.delete(); push_pair(16'h0060, 16'h0020); push_pair(16'h0040, 16'h0000);
        push_pair(16'h0060, 16'h0020); push_pair(16'h0000, 16'h0000);
        launch(20'h00400, 60, 0); wait_done(r);
        chk(r == 2'b01, "R5 re-armed confirm", r, 1);

        // R6 zero limit
        n_reads = 0;
        launch(20'h00500, 0, 0);
        chk(done == 1, "R6 done next cycle", done, 1);
        chk(busy == 0, "R6 busy low", busy, 0);
        chk(result == 2'b11, "R6 timeout", result, 3);
        @(negedge clk);
        chk(n_reads == 0, "R6 no reads", n_reads, 0);

        // R7 small limit, toggling forever
        fq.delete(); toggle_forever = 1;
        launch(20'h00600, 4, 0); wait_done(r);
        chk(r == 2'b11, "R7 timeout small", r, 3);

        // R7 limit one below all-ones
        launch(20'h00610, CMAX - 1, 0); wait_done(r);
        chk(r == 2'b11, "R7 timeout near max", r, 3);
        toggle_forever = 0;

        // R8 all-ones limit, long toggling then stable
        fq.delete(); last_w = 16'h0000;
        for (int i = 0; i < 40; i++) push_pair(16'h0040, 16'h0000);
        push_pair(16'h0000, 16'h0000);
        launch(20'h00700, CMAX, 0); wait_done(r);
        chk(r == 2'b01, "R8 no timeout", r, 1);

        // R9 ready wait
        fq.delete(); push_pair(16'h0040, 16'h0040);
        dev_ready = 0;
        launch(20'h00800, CMAX, 1);
        for (int i = 0; i < 10; i++) begin
            chk(bus_rd == 0, "R9 no read before ready", bus_rd, 0);
            @(negedge clk);
        end
        dev_ready = 1;
        wait_done(r);
        chk(r == 2'b01, "R9 pass after ready", r, 1);

        // R7 ready never arrives
        n_reads = 0; dev_ready = 0;
        launch(20'h00900, 5, 1); wait_done(r);
        chk(r == 2'b11, "R7 timeout in ready wait", r, 3);
        chk(n_reads == 0, "R9 no reads without ready", n_reads, 0);
        dev_ready = 1;

        // R10 start while busy, slow bus
        lat = 3;
        fq.delete(); push_pair(16'h0040, 16'h0000); push_pair(16'h0000, 16'h0040);
        push_pair(16'h0040, 16'h0000); push_pair(16'h0000, 16'h0000);
        launch(20'h0A000, 60, 0);
        repeat (2) @(negedge clk);
        poll_addr = 20'h0BBBB; tmo_limit = 0; start = 1;
        @(negedge clk);
        start = 0;
        chk(bus_addr == 20'h0A000, "R10 address kept", bus_addr, 20'h0A000);
        wait_done(r);
        chk(r == 2'b01, "R10 running poll unchanged", r, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(done == 0 && busy == 0, "R10 single done", done, 0);
        end
        chk(result == 2'b01, "R11 result held", result, 1);
        lat = 0;

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule